// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This block is a purely combinational execution slice for the second byte of the bit-manipulation prefix group. It takes an 8-bit operand that has already been fetched from a register or from memory, the current flag byte and the 8-bit sub-opcode. It returns the new operand value, a write-back enable and the new flag byte. Decoding of the prefix byte itself, any indexed displacement and all memory traffic belong to the surrounding core.

The sub-opcode's two top bits pick one of four classes. The first class is the eight-way rotate/shift family, and the three middle bits pick the kind. The other three classes are test, clear and set of one operand bit, and the three middle bits give the bit index. The three low bits name the operand's source (code 6 meaning memory). The core uses them to route the operand and the result, and this unit ignores them. Each class has its own flag rule.

The unit holds no state, so it has no state machine, no states and no transitions. An input change reaches the outputs within the same cycle.

Top module: `rsb_unit`

## Requirements
- R1: Sub-opcode bits 7:6 select the class: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. `wr_en` is 1 for rotate/shift, clear and set. It is 0 for bit test, and in that case `opnd_out` equals `opnd_in`.
- R2: With bits 7:6 = 00, bits 5:3 = 0 rotates left circularly and bits 5:3 = 1 rotates right circularly. In both cases the bit that leaves is copied into the carry (flag bit 0) and into the opposite end.
- R3: Bits 5:3 = 2 rotates left through carry: the old carry enters bit 0 and bit 7 goes to carry. Bits 5:3 = 3 rotates right through carry: the old carry enters bit 7 and bit 0 goes to carry.
- R4: Bits 5:3 = 4 shifts left and inserts 0 at bit 0. Bits 5:3 = 6 shifts left and inserts 1 at bit 0. Both send bit 7 to carry.
- R5: Bits 5:3 = 5 shifts right and keeps bit 7. Bits 5:3 = 7 shifts right and inserts 0 at bit 7. Both send bit 0 to carry.
- R6: After any rotate/shift, flag bit 7 (sign) is result bit 7 and flag bit 6 (zero) is 1 when the result is 0. Flag bit 4 (half-carry) and flag bit 1 (subtract) are 0. Flag bit 2 (parity) is 1 when the result has an even number of ones.
- R7: For bit test of bit b (bits 5:3): zero and parity are both 1 when operand bit b is 0. Half-carry is 1 and subtract is 0. Carry is unchanged. Sign is 1 only when b = 7 and operand bit 7 is 1.
- R8: Clear and set change only operand bit b (bits 5:3), forcing it to 0 or to 1. All eight flag bits pass through unchanged.
- R9: Sub-opcode bits 2:0 have no effect on any output. Flag bits 5 and 3 pass through unchanged in every class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sub_op | input | 8 | Second byte of the prefixed instruction |
| opnd_in | input | 8 | Operand already selected by the core |
| flags_in | input | 8 | Current flags (S7 Z6 H4 P2 N1 C0) |
| opnd_out | output | 8 | New operand value |
| wr_en | output | 1 | Result is to be written back |
| flags_out | output | 8 | Updated flags |

## Verification
The embedded checks are immediate and are evaluated only when every input is a known 0 or 1. They therefore assume the core presents a fully driven operand, flag byte and sub-opcode together. The bench meets this by driving all three inputs from one task in the same time step, and it samples half a cycle later. It walks every kind and every bit index over edge operands (0x00, 0x01, 0x80, 0xFF) with both carry values. It then feeds a long run of pseudo-random fully defined vectors that covers every source code in bits 2:0.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    localparam int FL_S = 7;
    localparam int FL_Z = 6;
    localparam int FL_H = 4;
    localparam int FL_P = 2;
    localparam int FL_N = 1;
    localparam int FL_C = 0;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_TEST  = 2'b01,
        CLS_CLEAR = 2'b10,
        CLS_SET   = 2'b11
    } op_class_e;

    typedef enum logic [2:0] {
        SK_ROL_CIRC  = 3'd0,
        SK_ROR_CIRC  = 3'd1,
        SK_ROL_CARRY = 3'd2,
        SK_ROR_CARRY = 3'd3,
        SK_SHL_ZERO  = 3'd4,
        SK_SHR_SIGN  = 3'd5,
        SK_SHL_ONE   = 3'd6,
        SK_SHR_ZERO  = 3'd7
    } shift_kind_e;
endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
    import rsb_pkg::*;
(
    input  shift_kind_e       kind,
    input  logic [DATA_W-1:0] val,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int TOP = DATA_W - 1;

    always_comb begin
        unique case (kind)
            SK_ROL_CIRC:  begin res = {val[TOP-1:0], val[TOP]}; cout = val[TOP]; end
            SK_ROR_CIRC:  begin res = {val[0], val[TOP:1]};     cout = val[0];   end
            SK_ROL_CARRY: begin res = {val[TOP-1:0], cin};      cout = val[TOP]; end
            SK_ROR_CARRY: begin res = {cin, val[TOP:1]};        cout = val[0];   end
            SK_SHL_ZERO:  begin res = {val[TOP-1:0], 1'b0};     cout = val[TOP]; end
            SK_SHR_SIGN:  begin res = {val[TOP], val[TOP:1]};   cout = val[0];   end
            SK_SHL_ONE:   begin res = {val[TOP-1:0], 1'b1};     cout = val[TOP]; end
            SK_SHR_ZERO:  begin res = {1'b0, val[TOP:1]};       cout = val[0];   end
            default:      begin res = val;                      cout = cin;      end
        endcase
    end

    always_comb begin
        if (!$isunknown({kind, val, cin})) begin
            // R2
            circ_wrap_chk: assert (!(kind == SK_ROL_CIRC) || (res[0] == cout))
                else $error("circular left wrap bit differs from carry");
            // R5
            shr_sign_keep_chk: assert (!(kind == SK_SHR_SIGN) || (res[TOP] == val[TOP]))
                else $error("arithmetic right shift lost sign bit");
        end
    end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
    import rsb_pkg::*;
(
    input  op_class_e         cls,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] val,
    output logic [DATA_W-1:0] res,
    output logic              picked
);
    logic [DATA_W-1:0] sel_mask;

    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_dec
            assign sel_mask[g] = (idx == IDX_W'(g));
        end
    endgenerate

    assign picked = |(val & sel_mask);

    always_comb begin
        unique case (cls)
            CLS_CLEAR: res = val & ~sel_mask;
            CLS_SET:   res = val | sel_mask;
            default:   res = val;
        endcase
    end

    always_comb begin
        if (!$isunknown({cls, idx, val})) begin
            // R8
            single_bit_chk: assert (((res ^ val) & ~sel_mask) == '0)
                else $error("bit operation touched an unselected bit");
        end
    end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
    import rsb_pkg::*;
(
    input  logic [7:0] sub_op,
    input  logic [7:0] opnd_in,
    input  logic [7:0] flags_in,
    output logic [7:0] opnd_out,
    output logic       wr_en,
    output logic [7:0] flags_out
);
    op_class_e         cls;
    shift_kind_e       kind;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic [DATA_W-1:0] bit_res;
    logic              bit_picked;

    assign cls  = op_class_e'(sub_op[7:6]);
    assign kind = shift_kind_e'(sub_op[5:3]);
    assign idx  = sub_op[5:3];

    rsb_shifter u_shift (
        .kind (kind),
        .val  (opnd_in),
        .cin  (flags_in[FL_C]),
        .res  (sh_res),
        .cout (sh_cout)
    );

    rsb_bitop u_bit (
        .cls    (cls),
        .idx    (idx),
        .val    (opnd_in),
        .res    (bit_res),
        .picked (bit_picked)
    );

    always_comb begin
        flags_out = flags_in;
        opnd_out  = opnd_in;
        wr_en     = 1'b1;
        unique case (cls)
            CLS_SHIFT: begin
                opnd_out        = sh_res;
                flags_out[FL_S] = sh_res[DATA_W-1];
                flags_out[FL_Z] = (sh_res == '0);
                flags_out[FL_H] = 1'b0;
                flags_out[FL_P] = ~^sh_res;
                flags_out[FL_N] = 1'b0;
                flags_out[FL_C] = sh_cout;
            end
            CLS_TEST: begin
                wr_en           = 1'b0;
                flags_out[FL_S] = bit_picked && (idx == IDX_W'(DATA_W-1));
                flags_out[FL_Z] = ~bit_picked;
                flags_out[FL_H] = 1'b1;
                flags_out[FL_P] = ~bit_picked;
                flags_out[FL_N] = 1'b0;
            end
            default: begin
                opnd_out = bit_res;
            end
        endcase
    end

    always_comb begin
        if (!$isunknown({sub_op, opnd_in, flags_in})) begin
            // R1
            test_nowrite_chk: assert (!(sub_op[7:6] == 2'b01) || (!wr_en && opnd_out == opnd_in))
                else $error("bit test wrote back");
            // R8
            bitmod_flags_hold_chk: assert (!sub_op[7] || (flags_out == flags_in))
                else $error("clear/set altered flags");
            // R6
            shift_hn_clear_chk: assert (!(sub_op[7:6] == 2'b00) || (!flags_out[FL_H] && !flags_out[FL_N]))
                else $error("shift left half-carry or subtract set");
            // R7
            test_carry_hold_chk: assert (!(sub_op[7:6] == 2'b01) || (flags_out[FL_C] == flags_in[FL_C] && flags_out[FL_H]))
                else $error("bit test flag rule broken");
            // R9
            spare_flags_chk: assert (flags_out[5] == flags_in[5] && flags_out[3] == flags_in[3])
                else $error("spare flag bits altered");
        end
    end
endmodule

// File: tb/rsb_unit_tb.sv
module rsb_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] sub_op = 8'h00, opnd_in = 8'h00, flags_in = 8'h00;
    logic [7:0] opnd_out, flags_out;
    logic       wr_en;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsb_unit u_dut (
        .sub_op(sub_op), .opnd_in(opnd_in), .flags_in(flags_in),
        .opnd_out(opnd_out), .wr_en(wr_en), .flags_out(flags_out)
    );

    function automatic string tag_of(input logic [7:0] op);
        int grp = op[7:6];
        int k = op[5:3];
        if (grp == 1) return "R7";
        if (grp >= 2) return "R8";
        if (k < 2) return "R2";
        if (k < 4) return "R3";
        if (k == 4 || k == 6) return "R4";
        return "R5";
    endfunction

    task automatic model(input logic [7:0] op, input logic [7:0] v, input logic [7:0] f,
                         output logic [7:0] eo, output logic ew, output logic [7:0] ef);
        int grp = op[7:6];
        int b = op[5:3];
        int x = v;
        int c = f[0];
        int r = 0;
        int nc = 0;
        int ones = 0;
        ef = f; eo = v; ew = 1'b1;
        if (grp == 0) begin
            case (b)
                0: begin nc = x / 128; r = (x * 2) % 256 + nc; end
                1: begin nc = x % 2; r = x / 2 + nc * 128; end
                2: begin nc = x / 128; r = (x * 2) % 256 + c; end
                3: begin nc = x % 2; r = x / 2 + c * 128; end
                4: begin nc = x / 128; r = (x * 2) % 256; end
                5: begin nc = x % 2; r = x / 2 + (x / 128) * 128; end
                6: begin nc = x / 128; r = (x * 2) % 256 + 1; end
                default: begin nc = x % 2; r = x / 2; end
            endcase
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            eo = 8'(r);
            ef[7] = (r >= 128); ef[6] = (r == 0); ef[4] = 0;
            ef[2] = (ones % 2 == 0); ef[1] = 0; ef[0] = nc[0];
        end else if (grp == 1) begin
            ew = 1'b0;
            ef[6] = (((x >> b) & 1) == 0); ef[2] = ef[6];
            ef[4] = 1; ef[1] = 0;
            ef[7] = (b == 7) && (((x >> 7) & 1) == 1);
        end else if (grp == 2) begin
            eo = 8'(x & ~(1 << b));
        end else begin
            eo = 8'(x | (1 << b));
        end
    endtask

    task automatic apply(input logic [7:0] op, input logic [7:0] v, input logic [7:0] f,
                         input string tag);
        logic [7:0] eo, ef;
        logic ew;
        @(posedge clk); #1;
        sub_op = op; opnd_in = v; flags_in = f;
        model(op, v, f, eo, ew, ef);
        @(negedge clk);
        checks++;
        if (opnd_out !== eo || wr_en !== ew || flags_out !== ef) begin
            errors++;
            $display("FAIL %s op=%h in=%h f=%h actual out=%h we=%b fl=%h expected out=%h we=%b fl=%h",
                     tag, op, v, f, opnd_out, wr_en, flags_out, eo, ew, ef);
        end
    endtask

    initial begin
        logic [7:0] o1, f1;
        logic w1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: circular left of 0, zero and parity set (R6)
        apply(8'h00, 8'h00, 8'h00, "R6");
        // R1 class decode and write enable on each class
        apply(8'h47, 8'h5A, 8'h00, "R1");
        apply(8'h87, 8'h5A, 8'h00, "R1");
        apply(8'hC7, 8'h5A, 8'h00, "R1");
        // R2 R3 R4 R5: every kind on edge operands, both carries
        for (int k = 0; k < 8; k++)
            foreach (o1[j]) begin
                logic [7:0] pat;
                pat = (j % 4 == 0) ? 8'h00 : (j % 4 == 1) ? 8'h01 : (j % 4 == 2) ? 8'h80 : 8'hFF;
                apply(8'(k * 8), pat, (j < 4) ? 8'h00 : 8'h01, tag_of(8'(k * 8)));
            end
        // R7: every bit index, operand clear and full, flags preset
        for (int b = 0; b < 8; b++) begin
            apply(8'(8'h40 + b * 8), 8'h00, 8'hFF, "R7");
            apply(8'(8'h40 + b * 8), 8'hFF, 8'h00, "R7");
            apply(8'(8'h40 + b * 8), 8'(1 << b), 8'h29, "R7");
        end
        // R8: clear and set on each index, flags must hold
        for (int b = 0; b < 8; b++) begin
            apply(8'(8'h80 + b * 8), 8'hFF, 8'hD7, "R8");
            apply(8'(8'hC0 + b * 8), 8'h00, 8'h28, "R8");
        end
        // R9: source code field ignored, spare flags pass
        for (int s = 0; s < 8; s++) begin
            apply(8'(8'h10 + s), 8'hA5, 8'h28, "R9");
            checks++;
            if (s == 0) begin o1 = opnd_out; f1 = flags_out; w1 = wr_en; end
            else if (opnd_out !== o1 || flags_out !== f1 || wr_en !== w1) begin
                errors++;
                $display("FAIL R9 src=%0d actual %h/%h/%b expected %h/%h/%b",
                         s, opnd_out, flags_out, wr_en, o1, f1, w1);
            end
        end
        // Pseudo-random fully defined vectors, all classes (R1..R9)
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] op;
            op = 8'($urandom);
            apply(op, 8'($urandom), 8'($urandom), tag_of(op));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule